// File: doc/BRIEF.md
# Repeated String Operation Engine

This block runs one block-string operation under a repeat prefix. A caller loads a source index, a destination index, an element count, an accumulator value, a direction bit, an element size (byte or word), an operation code and a repeat mode with a one-cycle start pulse. The engine then walks the strings one element at a time through a single-port memory port with a request/ready handshake. When it finishes it returns the final index, count and accumulator values together with the zero and carry flags.

Five operations are available. Copy moves elements from the source string to the destination string. Compare and scan set flags from an element comparison: compare checks the source string against the destination string, and scan checks the accumulator against the destination string. Load reads the source string into the accumulator, and store writes the accumulator into the destination string. The two conditional repeat modes let compare and scan stop before the count is used up. A fixed setup delay comes before the first element, as a microcoded sequencer would have. Memory is byte addressed and little-endian, and a word element takes two consecutive bytes.

Top module: `strm_engine`

## Requirements
- R1: A high `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle after `done`, and a `start` given while busy has no effect.
- R2: If the count is zero, or the operation code is 5, 6 or 7, the run makes no memory request. `done` is then first seen after the (SETUP_CYC+2)-th rising edge, where the edge that samples `start` is the first (the fifth with the default SETUP_CYC=3). Indexes, count and accumulator come back unchanged, and both flags read 0.
- R3: Copy (op code 0) reads one element at the source index and then writes that same element at the destination index. A full run makes exactly count reads and count writes.
- R4: Each element moves an index by 1 for a byte element (`elem_word`=0) or by 2 for a word element (`elem_word`=1). The index goes up when `dir_down`=0 and down when `dir_down`=1. Copy and compare move both indexes. Scan (op 2) and store (op 4) move only the destination index. Load (op 3) moves only the source index.
- R5: Compare (op code 1) reads the source element and then the destination element. It sets zf when the two are equal and sets cf when the source element is unsigned-below the destination element. Only the element width is compared, and memory is not written.
- R6: Scan (op code 2) compares the accumulator element (the low byte for byte elements) with the destination element, using the same flag rules as compare.
- R7: Load (op code 3) puts the element into the accumulator. A word element replaces all 16 bits. A byte element replaces bits 7:0 and keeps bits 15:8.
- R8: Store (op code 4) writes the accumulator element at the destination index. A byte store changes exactly one memory byte.
- R9: The count goes down by exactly one per completed element. With repeat mode 0 or 3 the run ends when the count reaches zero.
- R10: Repeat mode 1 (repeat while equal) ends a compare or scan after the first element that clears zf. Repeat mode 2 (repeat while unequal) ends it after the first element that sets zf. The count that remains is reported. For copy, load and store, modes 1 and 2 behave like mode 0.
- R11: While `mem_req` is high and `mem_ready` is low, the request, address, write enable and write data stay stable. An access completes on an edge where both are high. A byte access uses bits 7:0 of the data buses.
- R12: `done` is a one-cycle pulse, and `mem_req` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run with the operands below |
| op_code | input | 3 | 0 copy, 1 compare, 2 scan, 3 load, 4 store |
| rep_mode | input | 2 | 0/3 plain repeat, 1 while equal, 2 while unequal |
| dir_down | input | 1 | 1 moves the indexes downward |
| elem_word | input | 1 | 1 selects 16-bit elements, 0 selects bytes |
| src_in | input | AW | Initial source index |
| dst_in | input | AW | Initial destination index |
| cnt_in | input | CW | Initial element count |
| acc_in | input | 2*BYTE_W | Initial accumulator |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_word | output | 1 | Access width, 1 word, 0 byte |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 2*BYTE_W | Write data |
| mem_rdata | input | 2*BYTE_W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Access completes on this edge |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_out | output | AW | Current source index |
| dst_out | output | AW | Current destination index |
| cnt_out | output | CW | Current remaining count |
| acc_out | output | 2*BYTE_W | Current accumulator |
| zf_out | output | 1 | Zero flag of the last comparison |
| cf_out | output | 1 | Carry (unsigned below) flag of the last comparison |

## Verification
The bound checker watches several rules on every cycle. It checks that a stalled request stays stable and that `done` stays a single pulse. It checks that memory is touched only while busy. It checks that the count only ever falls by one and that each index moves only by the element stride. What the bench scenarios alone can show is the data behaviour: what was copied or stored at which bytes, the flag values, the accumulator lane rules, the exact point where a conditional repeat stops, and how long a zero-count run takes. For these the bench compares the memory image and the returned values with a reference model it runs alongside, with random wait states on the memory port.

// File: rtl/strm_pkg.sv
package strm_pkg;
   typedef enum logic [2:0] {
      OP_COPY  = 3'd0,
      OP_CMP   = 3'd1,
      OP_SCAN  = 3'd2,
      OP_LOAD  = 3'd3,
      OP_STORE = 3'd4
   } strm_op_e;

   typedef enum logic [1:0] {
      REP_PLAIN    = 2'd0,
      REP_WHILE_EQ = 2'd1,
      REP_WHILE_NE = 2'd2,
      REP_PLAIN_B  = 2'd3
   } strm_rep_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CHECK,
      ST_RD_A,
      ST_RD_B,
      ST_WR,
      ST_STEP,
      ST_DONE
   } strm_state_e;
endpackage

// File: rtl/strm_index_step.sv
module strm_index_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] idx_i,
   input  logic          dir_down_i,
   input  logic          word_i,
   input  logic          advance_i,
   output logic [AW-1:0] idx_o
);
   localparam logic [AW-1:0] STEP_B = AW'(1);
   localparam logic [AW-1:0] STEP_W = AW'(2);

   logic [AW-1:0] stride;

   always_comb begin
      stride = word_i ? STEP_W : STEP_B;
      if (!advance_i)
         idx_o = idx_i;
      else if (dir_down_i)
         idx_o = idx_i - stride;
      else
         idx_o = idx_i + stride;
   end
endmodule

// File: rtl/strm_flag_eval.sv
module strm_flag_eval #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] a_i,
   input  logic [2*BYTE_W-1:0] b_i,
   input  logic                word_i,
   output logic                zf_o,
   output logic                cf_o
);
   localparam int LANES = 2;

   logic [LANES-1:0] lane_eq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (a_i[g*BYTE_W +: BYTE_W] == b_i[g*BYTE_W +: BYTE_W]);
   end

   always_comb begin
      zf_o = lane_eq[0] & (word_i ? lane_eq[1] : 1'b1);
      cf_o = word_i ? (a_i < b_i) : (a_i[BYTE_W-1:0] < b_i[BYTE_W-1:0]);
   end
endmodule

// File: rtl/strm_delay.sv
module strm_delay #(
   parameter int CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic last_o
);
   localparam int DLY_W = (CYC < 2) ? 1 : $clog2(CYC);
   localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(CYC - 1);

   logic [DLY_W-1:0] dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dly_q <= '0;
      else if (load_i)
         dly_q <= DLY_INIT;
      else if (run_i && dly_q != '0)
         dly_q <= dly_q - DLY_W'(1);
   end

   assign last_o = (dly_q == '0);
endmodule

// File: rtl/strm_engine.sv
module strm_engine
   import strm_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter int BYTE_W    = 8,
   parameter int SETUP_CYC = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2:0]          op_code,
   input  logic [1:0]          rep_mode,
   input  logic                dir_down,
   input  logic                elem_word,
   input  logic [AW-1:0]       src_in,
   input  logic [AW-1:0]       dst_in,
   input  logic [CW-1:0]       cnt_in,
   input  logic [2*BYTE_W-1:0] acc_in,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_word,
   output logic [AW-1:0]       mem_addr,
   output logic [2*BYTE_W-1:0] mem_wdata,
   input  logic [2*BYTE_W-1:0] mem_rdata,
   input  logic                mem_ready,
   output logic                busy,
   output logic                done,
   output logic [AW-1:0]       src_out,
   output logic [AW-1:0]       dst_out,
   output logic [CW-1:0]       cnt_out,
   output logic [2*BYTE_W-1:0] acc_out,
   output logic                zf_out,
   output logic                cf_out
);
   localparam int DW = 2 * BYTE_W;

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (AW < 2) begin : g_bad_aw
      $error("AW must be at least 2");
   end
   if (CW < 1 || BYTE_W < 1) begin : g_bad_w
      $error("CW and BYTE_W must be positive");
   end

   strm_state_e   st_q;
   strm_op_e      op_q;
   strm_rep_e     mode_q;
   logic          valid_op_q;
   logic          dir_q, word_q, stop_q;
   logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
   logic [CW-1:0] cnt_q;
   logic [DW-1:0] acc_q, opa_q, rd_elem, acc_elem, cmp_a;
   logic          zf_q, cf_q, zf_nx, cf_nx;
   logic          dly_last, access_ok;
   logic          adv_src, adv_dst, is_test, stop_nx;

   // ---------------- setup delay ----------------
   strm_delay #(.CYC(SETUP_CYC)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (st_q == ST_IDLE && start),
      .run_i  (st_q == ST_SETUP),
      .last_o (dly_last)
   );

   // ---------------- index advance ----------------
   always_comb begin
      adv_src = (op_q == OP_COPY) || (op_q == OP_CMP) || (op_q == OP_LOAD);
      adv_dst = (op_q == OP_COPY) || (op_q == OP_CMP) ||
                (op_q == OP_SCAN) || (op_q == OP_STORE);
   end

   strm_index_step #(.AW(AW)) u_src_step (
      .idx_i      (src_q),
      .dir_down_i (dir_q),
      .word_i     (word_q),
      .advance_i  (adv_src),
      .idx_o      (src_nx)
   );

   strm_index_step #(.AW(AW)) u_dst_step (
      .idx_i      (dst_q),
      .dir_down_i (dir_q),
      .word_i     (word_q),
      .advance_i  (adv_dst),
      .idx_o      (dst_nx)
   );

   // ---------------- element data and flags ----------------
   always_comb begin
      rd_elem  = word_q ? mem_rdata : {{BYTE_W{1'b0}}, mem_rdata[BYTE_W-1:0]};
      acc_elem = word_q ? acc_q     : {{BYTE_W{1'b0}}, acc_q[BYTE_W-1:0]};
      cmp_a    = (op_q == OP_SCAN) ? acc_elem : opa_q;
      is_test  = (op_q == OP_CMP) || (op_q == OP_SCAN);
      stop_nx  = is_test && (((mode_q == REP_WHILE_EQ) && !zf_q) ||
                             ((mode_q == REP_WHILE_NE) &&  zf_q));
   end

   strm_flag_eval #(.BYTE_W(BYTE_W)) u_flags (
      .a_i    (cmp_a),
      .b_i    (mem_rdata),
      .word_i (word_q),
      .zf_o   (zf_nx),
      .cf_o   (cf_nx)
   );

   assign access_ok = mem_ready;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         op_q       <= OP_COPY;
         mode_q     <= REP_PLAIN;
         valid_op_q <= 1'b0;
         dir_q      <= 1'b0;
         word_q     <= 1'b0;
         stop_q     <= 1'b0;
         src_q      <= '0;
         dst_q      <= '0;
         cnt_q      <= '0;
         acc_q      <= '0;
         opa_q      <= '0;
         zf_q       <= 1'b0;
         cf_q       <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q       <= ST_SETUP;
                  op_q       <= strm_op_e'(op_code);
                  valid_op_q <= (op_code <= 3'd4);
                  mode_q     <= strm_rep_e'(rep_mode);
                  dir_q      <= dir_down;
                  word_q     <= elem_word;
                  src_q      <= src_in;
                  dst_q      <= dst_in;
                  cnt_q      <= cnt_in;
                  acc_q      <= acc_in;
                  stop_q     <= 1'b0;
                  zf_q       <= 1'b0;
                  cf_q       <= 1'b0;
               end
            end
            ST_SETUP: begin
               if (dly_last)
                  st_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (cnt_q == '0 || stop_q || !valid_op_q)
                  st_q <= ST_DONE;
               else begin
                  case (op_q)
                     OP_SCAN:  st_q <= ST_RD_B;
                     OP_STORE: st_q <= ST_WR;
                     default:  st_q <= ST_RD_A;
                  endcase
               end
            end
            ST_RD_A: begin
               if (access_ok) begin
                  opa_q <= rd_elem;
                  case (op_q)
                     OP_COPY: st_q <= ST_WR;
                     OP_CMP:  st_q <= ST_RD_B;
                     default: begin
                        acc_q <= word_q ? mem_rdata
                                        : {acc_q[DW-1:BYTE_W], mem_rdata[BYTE_W-1:0]};
                        st_q  <= ST_STEP;
                     end
                  endcase
               end
            end
            ST_RD_B: begin
               if (access_ok) begin
                  zf_q <= zf_nx;
                  cf_q <= cf_nx;
                  st_q <= ST_STEP;
               end
            end
            ST_WR: begin
               if (access_ok)
                  st_q <= ST_STEP;
            end
            ST_STEP: begin
               src_q  <= src_nx;
               dst_q  <= dst_nx;
               cnt_q  <= cnt_q - CW'(1);
               stop_q <= stop_nx;
               st_q   <= ST_CHECK;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- memory port ----------------
   always_comb begin
      mem_req   = (st_q == ST_RD_A) || (st_q == ST_RD_B) || (st_q == ST_WR);
      mem_we    = (st_q == ST_WR);
      mem_word  = word_q;
      mem_addr  = (st_q == ST_RD_A) ? src_q : dst_q;
      mem_wdata = (op_q == OP_STORE) ? acc_elem : opa_q;
   end

   assign busy    = (st_q != ST_IDLE);
   assign done    = (st_q == ST_DONE);
   assign src_out = src_q;
   assign dst_out = dst_q;
   assign cnt_out = cnt_q;
   assign acc_out = acc_q;
   assign zf_out  = zf_q;
   assign cf_out  = cf_q;
endmodule

// File: rtl/strm_engine_chk.sv
module strm_engine_chk #(
   parameter int AW     = 16,
   parameter int CW     = 16,
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic                mem_req,
   input logic                mem_ready,
   input logic                mem_we,
   input logic                mem_word,
   input logic [AW-1:0]       mem_addr,
   input logic [2*BYTE_W-1:0] mem_wdata,
   input logic [AW-1:0]       src_out,
   input logic [AW-1:0]       dst_out,
   input logic [CW-1:0]       cnt_out
);
   logic [AW-1:0] stride;
   assign stride = mem_word ? AW'(2) : AW'(1);

   assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_req_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && cnt_out != $past(cnt_out)) |->
         (cnt_out == $past(cnt_out) - CW'(1)));

   assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && src_out != $past(src_out)) |->
         (src_out == $past(src_out) + stride || src_out == $past(src_out) - stride));

   assert_dst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && dst_out != $past(dst_out)) |->
         (dst_out == $past(dst_out) + stride || dst_out == $past(dst_out) - stride));
endmodule

bind strm_engine strm_engine_chk #(.AW(AW), .CW(CW), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .mem_req   (mem_req),
   .mem_ready (mem_ready),
   .mem_we    (mem_we),
   .mem_word  (mem_word),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .src_out   (src_out),
   .dst_out   (dst_out),
   .cnt_out   (cnt_out)
);

// File: tb/strm_engine_tb.sv
module strm_engine_tb;
   localparam int AW = 16, CW = 16, BW = 8, DW = 16, SETUP = 3;

   logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [2:0]    op_code = '0;
   logic [1:0]    rep_mode = '0;
   logic          dir_down = 1'b0, elem_word = 1'b0;
   logic [AW-1:0] src_in = '0, dst_in = '0;
   logic [CW-1:0] cnt_in = '0;
   logic [DW-1:0] acc_in = '0;
   logic          mem_req, mem_we, mem_word, busy, done, zf_out, cf_out;
   logic [AW-1:0] mem_addr, src_out, dst_out;
   logic [DW-1:0] mem_wdata, acc_out;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ready = 1'b0;
   logic [CW-1:0] cnt_out;

   always #10 clk = ~clk;

   strm_engine #(.AW(AW), .CW(CW), .BYTE_W(BW), .SETUP_CYC(SETUP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .rep_mode(rep_mode), .dir_down(dir_down), .elem_word(elem_word),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .acc_in(acc_in),
      .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .busy(busy), .done(done), .src_out(src_out),
      .dst_out(dst_out), .cnt_out(cnt_out), .acc_out(acc_out),
      .zf_out(zf_out), .cf_out(cf_out)
   );

   int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0, cyc = 0;
   logic [7:0] mem [256];
   logic [7:0] emem [256];
   logic [AW-1:0] e_src, e_dst;
   logic [CW-1:0] e_cnt;
   logic [DW-1:0] e_acc;
   logic e_zf, e_cf;
   int e_rd, e_wr;

   // memory model with random wait states, acting at the falling edge
   always @(negedge clk) begin
      if (mem_req) begin
         mem_ready <= ($urandom % 3) != 0;
         if (mem_ready === 1'b0 || 1'b1) begin end
      end else
         mem_ready <= 1'b0;
   end
   always @(negedge clk) begin
      #1;
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            mem[mem_addr[7:0]] = mem_wdata[7:0];
            if (mem_word) mem[8'(mem_addr[7:0] + 8'd1)] = mem_wdata[15:8];
            n_wr++;
         end else begin
            mem_rdata = mem_word ? {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]}
                                 : {8'h00, mem[mem_addr[7:0]]};
            n_rd++;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mrd(input logic [AW-1:0] a, input logic w);
      return w ? {emem[8'(a[7:0] + 8'd1)], emem[a[7:0]]} : {8'h00, emem[a[7:0]]};
   endfunction

   task automatic mwr(input logic [AW-1:0] a, input logic w, input logic [15:0] d);
      emem[a[7:0]] = d[7:0];
      if (w) emem[8'(a[7:0] + 8'd1)] = d[15:8];
   endtask

   // reference model computed from the requirements
   task automatic model(input int op, input int md, input logic dn, input logic w,
                        input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                        input logic [CW-1:0] c0, input logic [DW-1:0] a0);
      logic [AW-1:0] s, d, st;
      logic [15:0] va, vb;
      logic z, cy;
      logic [CW-1:0] c;
      s = s0; d = d0; c = c0; e_acc = a0; z = 0; cy = 0; e_rd = 0; e_wr = 0;
      st = w ? AW'(2) : AW'(1);
      for (int k = 0; k < 256; k++) emem[k] = mem[k];
      if (op <= 4) begin
         while (c != 0) begin
            case (op)
               0: begin va = mrd(s, w); mwr(d, w, va); e_rd++; e_wr++;
                        s = dn ? s - st : s + st; d = dn ? d - st : d + st; end
               1: begin va = mrd(s, w); vb = mrd(d, w); e_rd += 2;
                        z = (va == vb); cy = (va < vb);
                        s = dn ? s - st : s + st; d = dn ? d - st : d + st; end
               2: begin va = w ? e_acc : {8'h00, e_acc[7:0]}; vb = mrd(d, w); e_rd++;
                        z = (va == vb); cy = (va < vb); d = dn ? d - st : d + st; end
               3: begin va = mrd(s, w); e_rd++;
                        e_acc = w ? va : {e_acc[15:8], va[7:0]}; s = dn ? s - st : s + st; end
               default: begin mwr(d, w, w ? e_acc : {8'h00, e_acc[7:0]}); e_wr++;
                        d = dn ? d - st : d + st; end
            endcase
            c = c - CW'(1);
            if ((op == 1 || op == 2) && ((md == 1 && !z) || (md == 2 && z))) break;
         end
      end
      e_src = s; e_dst = d; e_cnt = c; e_zf = z; e_cf = cy;
   endtask

   // runs one operation; returns the number of rising edges until done is seen
   task automatic run(input int op, input int md, input logic dn, input logic w,
                      input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                      input logic [CW-1:0] c0, input logic [DW-1:0] a0, output int edges);
      @(negedge clk);
      model(op, md, dn, w, s0, d0, c0, a0);
      n_rd = 0; n_wr = 0;
      op_code = 3'(op); rep_mode = 2'(md); dir_down = dn; elem_word = w;
      src_in = s0; dst_in = d0; cnt_in = c0; acc_in = a0; start = 1'b1;
      edges = 0;
      while (edges < 3000) begin
         @(negedge clk);
         edges++;
         if (edges == 1) begin
            start = 1'b0;
            check("R1 busy after start", 32'(busy), 32'd1);
         end
         if (edges == 2) begin
            // start while busy must be ignored (R1): alter operands and pulse it
            start = 1'b1; src_in = 16'h0011; cnt_in = 16'h0007;
         end
         if (edges == 3) start = 1'b0;
         if (done) break;
      end
      if (edges >= 3000) begin
         n_chk++; n_bad++; $display("FAIL R1 run hung: act=%0d exp<3000", edges);
      end
   endtask

   task automatic compare_all(input string tag);
      int bad = 0;
      check({tag, " src R4"}, 32'(src_out), 32'(e_src));
      check({tag, " dst R4"}, 32'(dst_out), 32'(e_dst));
      check({tag, " cnt R9 R10"}, 32'(cnt_out), 32'(e_cnt));
      check({tag, " acc R7"}, 32'(acc_out), 32'(e_acc));
      check({tag, " zf R5 R6"}, 32'(zf_out), 32'(e_zf));
      check({tag, " cf R5 R6"}, 32'(cf_out), 32'(e_cf));
      check({tag, " reads R3"}, 32'(n_rd), 32'(e_rd));
      check({tag, " writes R3 R8"}, 32'(n_wr), 32'(e_wr));
      for (int k = 0; k < 256; k++) if (mem[k] !== emem[k]) bad++;
      check({tag, " memory R3 R8"}, 32'(bad), 32'd0);
   endtask

   task automatic fill(input int range);
      for (int k = 0; k < 256; k++) mem[k] = 8'($urandom % range);
   endtask

   initial begin
      int e;
      void'($urandom(32'h5EED_1234));
      fill(256);
      repeat (3) @(negedge clk);
      check("R12 reset done", 32'(done), 32'd0);
      check("R1 reset busy", 32'(busy), 32'd0);
      check("R12 reset req", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      // R2: zero count, fixed delay, no access
      run(0, 0, 1'b0, 1'b1, 16'h0040, 16'h0080, 16'd0, 16'hBEEF, e);
      check("R2 zero-count delay", 32'(e), 32'(SETUP + 2));
      compare_all("R2 zero");
      check("R12 done pulse", 32'(done), 32'd1);
      @(negedge clk);
      check("R12 done one cycle", 32'(done), 32'd0);

      // R2: reserved op code
      run(6, 0, 1'b0, 1'b0, 16'h0040, 16'h0080, 16'd5, 16'h1234, e);
      compare_all("R2 reserved op");

      // R10: scan while unequal stops at first match (third element)
      fill(256);
      mem[8'h60] = 8'h01; mem[8'h61] = 8'h02; mem[8'h62] = 8'h5A; mem[8'h63] = 8'h5A;
      run(2, 2, 1'b0, 1'b0, 16'h0000, 16'h0060, 16'd10, 16'h775A, e);
      check("R10 scan stop count", 32'(cnt_out), 32'd7);
      compare_all("R10 scan ne");

      // R10: compare while equal stops at first difference
      mem[8'h30] = 8'h11; mem[8'h31] = 8'h22; mem[8'h32] = 8'h33;
      mem[8'h90] = 8'h11; mem[8'h91] = 8'h22; mem[8'h92] = 8'h40;
      run(1, 1, 1'b0, 1'b0, 16'h0030, 16'h0090, 16'd8, 16'h0000, e);
      check("R10 cmp stop count", 32'(cnt_out), 32'd5);
      check("R5 cmp below", 32'(cf_out), 32'd1);
      compare_all("R10 cmp eq");

      // R8: byte store changes exactly one byte
      fill(256);
      run(4, 0, 1'b0, 1'b0, 16'h0000, 16'h00A0, 16'd1, 16'hC3A5, e);
      check("R8 byte lane", 32'(mem[8'hA0]), 32'hA5);
      compare_all("R8 byte store");

      // R7: byte load keeps upper half
      mem[8'h50] = 8'h3C;
      run(3, 0, 1'b1, 1'b0, 16'h0050, 16'h0000, 16'd1, 16'hAB00, e);
      check("R7 byte load", 32'(acc_out), 32'hAB3C);
      compare_all("R7 load");

      // R4 / R3: word copy downward
      run(0, 1, 1'b1, 1'b1, 16'h00B0, 16'h0070, 16'd6, 16'h0000, e);
      compare_all("R3 word copy down");

      // random mix
      for (int t = 0; t < 60; t++) begin
         int op, md;
         logic dn, w;
         fill((t % 2) ? 4 : 256);
         op = (($urandom % 12) == 0) ? 5 : int'($urandom % 5);
         md = int'($urandom % 4);
         dn = 1'($urandom); w = 1'($urandom);
         run(op, md, dn, w, 16'(16'h0040 + ($urandom % 128)), 16'(16'h0040 + ($urandom % 128)),
             16'($urandom % 13), 16'($urandom), e);
         compare_all($sformatf("rand%0d op%0d R3 R4 R5 R6 R7 R8 R9", t, op));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule